// File: doc/BRIEF.md
# NAND Page Write Sequencer

This block sits on the host side of a raw NAND flash bus and turns one page-write request into the full bus sequence that programs a page. A request gives a row address of three bytes, a start column, an optional spare-area flag and a byte count. The data bytes then arrive on a separate valid/ready stream. The sequencer drives chip enable, the command and address latch enables, and the write and read strobes. It sends the load command and the address bytes, streams the data bytes, and issues the confirm command.

After confirm, the device is busy. The sequencer waits for the end of programming in one of two selectable ways: it can watch the ready/busy line, or it can poll the status byte. It then decodes the outcome into a one-cycle response. A watchdog on the busy wait ends a stuck operation with a device reset. A request whose byte count cannot be programmed is refused before the chip is selected.

Strobe timing is set at run time. Each write or read strobe stays low for a set number of cycles and high for at least another set number. This lets one netlist meet the setup and hold times of slower or faster parts.

Top module: `nand_pgm_seq`

## Requirements
- R1: An accepted request produces write-strobe cycles in this order: command 50h only when the spare flag is set, command 80h, the four address cycles, the data bytes, then command 10h. After that come command 70h and status reads, plus command FFh on a timeout.
- R2: The address cycles are, in order: the column byte, row bits 7:0, row bits 15:8, and row bits 23:16. Each is marked by the address latch enable being high and the command latch enable low.
- R3: Exactly the requested number of bytes is taken from the data stream, and only on cycles where valid and ready are both high. They are written in arrival order, with both latch enables low. Idle cycles on the stream are tolerated.
- R4: A request with a byte count of 0, or above 528, is refused. No strobe is produced and chip enable stays high. Response code 3 appears two cycles after the accepting edge.
- R5: Every write or read strobe stays low for exactly cfg_we_lo cycles, where cfg_we_lo is 1 to 15. Between strobes, both strobes stay high for at least cfg_we_hi cycles. The latch enables and driven data do not change while the write strobe is low. The two strobes are never low together.
- R6: When cfg_poll is 0, the sequencer waits for the ready/busy line to be high (1 means ready). It then sends 70h and reads the status once.
- R7: When cfg_poll is 1, the sequencer sends 70h right after confirm. It then repeats status reads until status bit 6 reads 1.
- R8: When status bit 6 is 1, status bit 0 gives the response: code 0 means pass when the bit is 0, and code 1 means fail when the bit is 1.
- R9: While the device is busy, the only commands written are 70h or FFh. No address or data cycle is written.
- R10: If the busy wait lasts TMO_CYCLES cycles without completion, command FFh is written and the response is code 2.
- R11: resp_valid is a pulse of exactly one cycle. Chip enable is high while the sequencer is idle, including out of reset, when req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_poll | input | 1 | 1: poll status bit 6; 0: watch ready/busy |
| cfg_we_lo | input | 4 | Strobe low time in cycles (1..15) |
| cfg_we_hi | input | 4 | Minimum strobe high time in cycles (1..15) |
| req_valid | input | 1 | Page-write request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_row | input | 24 | Page row address |
| req_col | input | 8 | Start column |
| req_spare | input | 1 | Start in the spare area (prefix 50h) |
| req_len | input | 10 | Number of data bytes |
| din_valid | input | 1 | Data byte present |
| din_ready | output | 1 | Data byte taken |
| din_data | input | 8 | Data byte |
| resp_valid | output | 1 | Response pulse |
| resp_code | output | 2 | 0 pass, 1 fail, 2 timeout, 3 refused |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Bus data driven |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_io_in | input | 8 | Bus data received |
| nf_rb | input | 1 | Ready/busy, 1 means ready |

## Verification
Two events can land in the same cycle: the end of a status read that reports ready, and the expiry of the busy-wait timer. Both are resolved in the status-read state. A ready result wins, and expiry only leads to reset when the read shows the device still busy. The bench drives busy times far past the timer limit in both wait modes, and also busy times well inside it. It then judges the response code and whether an FFh command ends the write log. A second overlap is a stall on the data stream in the same cycle as the end of a strobe. A periodic stall pattern provokes it, and it is judged by comparing every logged data byte with its arithmetic pattern.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_REJ, S_SPARE, S_LOAD, S_ADDR, S_DATA,
    S_CONFIRM, S_WRB, S_ST70, S_STRD, S_RST
  } seq_state_t;

  localparam logic [1:0] RESP_PASS = 2'd0;
  localparam logic [1:0] RESP_FAIL = 2'd1;
  localparam logic [1:0] RESP_TMO  = 2'd2;
  localparam logic [1:0] RESP_REJ  = 2'd3;

  localparam logic [7:0] OP_SPARE   = 8'h50;
  localparam logic [7:0] OP_LOAD    = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  localparam int ST_READY_BIT = 6;
  localparam int ST_FAIL_BIT  = 0;
endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd,
  input  logic [CW-1:0] lo_cyc,
  input  logic [CW-1:0] hi_cyc,
  input  logic [7:0]    io_in,
  output logic          we_n,
  output logic          re_n,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rdata
);
  logic          busy_q, busy_n;
  logic          low_q, low_n;
  logic          rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [7:0]    rdata_q;
  logic          last_lo, last_hi, cap_en;

  assign last_lo = low_q && (cnt_q == lo_cyc - 1'b1);
  assign last_hi = !low_q && (cnt_q == hi_cyc - 1'b1);
  assign cap_en  = busy_q && last_lo && rd_q;

  always_comb begin
    busy_n = busy_q;
    low_n  = low_q;
    rd_n   = rd_q;
    cnt_n  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        low_n  = 1'b1;
        rd_n   = rd;
        cnt_n  = '0;
      end
    end else if (low_q) begin
      if (last_lo) begin
        low_n = 1'b0;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (last_hi) begin
      busy_n = 1'b0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      low_q  <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      low_q  <= low_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= io_in;
  end

  assign we_n  = !(busy_q && low_q && !rd_q);
  assign re_n  = !(busy_q && low_q && rd_q);
  assign busy  = busy_q;
  assign done  = busy_q && last_hi;
  assign rdata = rdata_q;
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int LIMIT = 100000,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] cnt_q;

  assign expired = (cnt_q == TW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq
  import nand_pgm_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int ROW_BYTES  = 3,
  parameter int TMO_CYCLES = 100000,
  parameter int WB_GUARD   = 3,
  parameter int STW        = 4,
  localparam int LEN_W     = $clog2(PAGE_BYTES + 1),
  localparam int ROW_W     = 8 * ROW_BYTES,
  localparam int ADDR_CYC  = ROW_BYTES + 1,
  localparam int AI_W      = $clog2(ADDR_CYC),
  localparam int GW        = $clog2(WB_GUARD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_poll,
  input  logic [STW-1:0]   cfg_we_lo,
  input  logic [STW-1:0]   cfg_we_hi,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [7:0]       req_col,
  input  logic             req_spare,
  input  logic [LEN_W-1:0] req_len,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  output logic             resp_valid,
  output logic [1:0]       resp_code,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_io_out,
  output logic             nf_io_oe,
  input  logic [7:0]       nf_io_in,
  input  logic             nf_rb
);
  seq_state_t state_q, state_n;
  logic [8*ADDR_CYC-1:0] addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [AI_W-1:0]  aidx_q;
  logic [GW-1:0]    guard_q;
  logic cle_q, ale_q, oe_q, ce_n_q, resp_v_q;
  logic [7:0] io_q;
  logic [1:0] resp_q, resp_n;
  logic sb_start, sb_rd, sb_busy, sb_done;
  logic [7:0] sb_rdata, cyc_byte;
  logic cyc_cle, cyc_ale, resp_set, load, aidx_inc, rem_dec;
  logic tmr_run, tmr_clr, tmo, len_bad, guard_ok;

  assign len_bad  = (req_len == '0) || (req_len > LEN_W'(PAGE_BYTES));
  assign guard_ok = (guard_q == GW'(WB_GUARD));

  always_comb begin
    state_n = state_q;  sb_start = 1'b0; sb_rd = 1'b0;
    cyc_cle = 1'b0;     cyc_ale = 1'b0;  cyc_byte = 8'h00;
    resp_set = 1'b0;    resp_n = RESP_PASS;
    req_ready = 1'b0;   din_ready = 1'b0; load = 1'b0;
    aidx_inc = 1'b0;    rem_dec = 1'b0;
    tmr_run = 1'b0;     tmr_clr = 1'b0;
    case (state_q)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          load = 1'b1;
          if (len_bad)        state_n = S_REJ;
          else if (req_spare) state_n = S_SPARE;
          else                state_n = S_LOAD;
        end
      end
      S_REJ: begin
        resp_set = 1'b1; resp_n = RESP_REJ; state_n = S_IDLE;
      end
      S_SPARE: begin
        sb_start = !sb_busy; cyc_cle = 1'b1; cyc_byte = OP_SPARE;
        if (sb_done) state_n = S_LOAD;
      end
      S_LOAD: begin
        sb_start = !sb_busy; cyc_cle = 1'b1; cyc_byte = OP_LOAD;
        if (sb_done) state_n = S_ADDR;
      end
      S_ADDR: begin
        sb_start = !sb_busy; cyc_ale = 1'b1;
        cyc_byte = addr_q[8*aidx_q +: 8];
        if (sb_done) begin
          aidx_inc = 1'b1;
          if (aidx_q == AI_W'(ADDR_CYC - 1)) state_n = S_DATA;
        end
      end
      S_DATA: begin
        din_ready = !sb_busy;
        sb_start  = din_valid && !sb_busy;
        cyc_byte  = din_data;
        if (sb_done) begin
          rem_dec = 1'b1;
          if (rem_q == LEN_W'(1)) state_n = S_CONFIRM;
        end
      end
      S_CONFIRM: begin
        sb_start = !sb_busy; cyc_cle = 1'b1; cyc_byte = OP_CONFIRM;
        tmr_clr = 1'b1;
        if (sb_done) state_n = cfg_poll ? S_ST70 : S_WRB;
      end
      S_WRB: begin
        tmr_run = 1'b1;
        if (tmo)                     state_n = S_RST;
        else if (guard_ok && nf_rb)  state_n = S_ST70;
      end
      S_ST70: begin
        tmr_run = 1'b1;
        sb_start = !sb_busy; cyc_cle = 1'b1; cyc_byte = OP_STATUS;
        if (sb_done) state_n = S_STRD;
      end
      S_STRD: begin
        tmr_run = 1'b1;
        sb_start = !sb_busy; sb_rd = 1'b1;
        if (sb_done) begin
          if (sb_rdata[ST_READY_BIT]) begin
            resp_set = 1'b1;
            resp_n   = sb_rdata[ST_FAIL_BIT] ? RESP_FAIL : RESP_PASS;
            state_n  = S_IDLE;
          end else if (tmo) begin
            state_n = S_RST;
          end
        end
      end
      S_RST: begin
        sb_start = !sb_busy; cyc_cle = 1'b1; cyc_byte = OP_RESET;
        if (sb_done) begin
          resp_set = 1'b1; resp_n = RESP_TMO; state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      resp_v_q <= 1'b0;
      resp_q <= RESP_PASS;
      ce_n_q <= 1'b1;
    end else begin
      state_q  <= state_n;
      resp_v_q <= resp_set;
      if (resp_set) resp_q <= resp_n;
      ce_n_q <= (state_n == S_IDLE) || (state_n == S_REJ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; rem_q <= '0; aidx_q <= '0; guard_q <= '0;
    end else begin
      if (load) begin
        addr_q <= {req_row, req_col};
        rem_q  <= req_len;
        aidx_q <= '0;
      end else begin
        if (aidx_inc) aidx_q <= aidx_q + 1'b1;
        if (rem_dec)  rem_q  <= rem_q - 1'b1;
      end
      if (tmr_clr)                              guard_q <= '0;
      else if (state_q == S_WRB && !guard_ok)   guard_q <= guard_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cle_q <= 1'b0; ale_q <= 1'b0; oe_q <= 1'b0; io_q <= 8'h00;
    end else if (sb_start) begin
      cle_q <= cyc_cle; ale_q <= cyc_ale; oe_q <= !sb_rd; io_q <= cyc_byte;
    end else if (state_n == S_IDLE) begin
      cle_q <= 1'b0; ale_q <= 1'b0; oe_q <= 1'b0;
    end
  end

  nand_strobe_gen #(.CW(STW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(sb_start), .rd(sb_rd),
    .lo_cyc(cfg_we_lo), .hi_cyc(cfg_we_hi), .io_in(nf_io_in),
    .we_n(nf_we_n), .re_n(nf_re_n), .busy(sb_busy), .done(sb_done),
    .rdata(sb_rdata)
  );

  nand_wait_timer #(.LIMIT(TMO_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .expired(tmo)
  );

  assign resp_valid = resp_v_q;
  assign resp_code  = resp_q;
  assign nf_ce_n    = ce_n_q;
  assign nf_cle     = cle_q;
  assign nf_ale     = ale_q;
  assign nf_io_out  = io_q;
  assign nf_io_oe   = oe_q;
endmodule

// File: rtl/nand_pgm_seq_chk.sv
module nand_pgm_seq_chk #(
  parameter int PAGE_BYTES = 528,
  parameter int LEN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             resp_valid,
  input logic [1:0]       resp_code,
  input logic             nf_ce_n,
  input logic             nf_cle,
  input logic             nf_ale,
  input logic             nf_we_n,
  input logic             nf_re_n,
  input logic [7:0]       nf_io_out,
  input logic             nf_rb
);
  logic bad_len;
  assign bad_len = (req_len == '0) || (req_len > LEN_W'(PAGE_BYTES));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && !$past(nf_we_n)) |->
      ($stable(nf_io_out) && $stable(nf_cle) && $stable(nf_ale)));

  p_ce_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  p_idle_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nf_ce_n);

  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_busy_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_rb && !nf_we_n) |->
      (nf_cle && (nf_io_out == 8'h70 || nf_io_out == 8'hFF)));

  p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_len) |=> nf_ce_n);

  p_reject_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_len) |=> ##1 (resp_valid && resp_code == 2'd3));
endmodule

bind nand_pgm_seq nand_pgm_seq_chk #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .resp_valid(resp_valid), .resp_code(resp_code),
  .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
  .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_rb(nf_rb)
);

// File: tb/nand_pgm_seq_bench.sv
module nand_pgm_seq_bench;
  localparam int CLK_NS = 10;
  localparam int TMO = 400;
  localparam int PAGE = 528;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_poll;
  logic [3:0] cfg_we_lo, cfg_we_hi;
  logic req_valid, req_ready, req_spare;
  logic [23:0] req_row;
  logic [7:0] req_col;
  logic [9:0] req_len;
  logic din_valid, din_ready;
  logic [7:0] din_data;
  logic resp_valid;
  logic [1:0] resp_code;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, nf_rb;
  logic [7:0] nf_io_out, nf_io_in;

  always #(CLK_NS/2) clk = ~clk;

  nand_pgm_seq #(.TMO_CYCLES(TMO)) u_nand_pgm_seq (
    .clk(clk), .rst_n(rst_n), .cfg_poll(cfg_poll), .cfg_we_lo(cfg_we_lo),
    .cfg_we_hi(cfg_we_hi), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_spare(req_spare),
    .req_len(req_len), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .resp_valid(resp_valid), .resp_code(resp_code),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
    .nf_io_in(nf_io_in), .nf_rb(nf_rb)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int wd = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // device model
  bit tst_clr = 1;
  int busy_len = 0, busy_cnt = 0;
  bit fail_flag = 0;
  int exp_lo = 1, exp_hi = 1;
  int log_n = 0, n_reads = 0, bad_w = 0, bad_cmd = 0;
  int lo_cnt = 0, re_cnt = 0, hi_cnt = 0;
  bit seen_fall = 0, ce_seen = 0;
  logic we_last = 1'b1, re_last = 1'b1;
  logic [1:0] log_k [0:1023];
  logic [7:0] log_v [0:1023];

  assign nf_rb = (busy_cnt == 0);
  assign nf_io_in = {1'b0, nf_rb, 5'b00000, fail_flag};

  always @(posedge clk) begin
    if (tst_clr) begin
      log_n = 0; n_reads = 0; bad_w = 0; bad_cmd = 0;
      lo_cnt = 0; re_cnt = 0; hi_cnt = 0; seen_fall = 0; ce_seen = 0;
      busy_cnt <= 0;
    end else begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (!nf_ce_n) ce_seen = 1;
      if (!nf_we_n) lo_cnt++;
      if (!nf_re_n) re_cnt++;
      if (nf_we_n && nf_re_n && !nf_ce_n) hi_cnt++;
      if ((we_last && !nf_we_n) || (re_last && !nf_re_n)) begin
        if (seen_fall && hi_cnt < exp_hi) bad_w++;
        seen_fall = 1; hi_cnt = 0;
      end
      if (!we_last && nf_we_n) begin
        if (lo_cnt != exp_lo) bad_w++;
        lo_cnt = 0;
        log_k[log_n] = nf_cle ? 2'd1 : (nf_ale ? 2'd2 : 2'd0);
        log_v[log_n] = nf_io_out;
        log_n++;
        if (busy_cnt > 0 && !(nf_cle && (nf_io_out == 8'h70 || nf_io_out == 8'hFF)))
          bad_cmd++;
        if (nf_cle && nf_io_out == 8'h10) busy_cnt <= busy_len;
        if (nf_cle && nf_io_out == 8'hFF) busy_cnt <= 0;
      end
      if (!re_last && nf_re_n) begin
        if (re_cnt != exp_lo) bad_w++;
        re_cnt = 0; n_reads++;
      end
    end
    we_last = nf_we_n;
    re_last = nf_re_n;
  end

  // data source
  int src_idx = 0, src_len = 0;
  bit stall_en = 0;
  logic [1:0] cyc = 2'b00;
  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    if (tst_clr) src_idx <= 0;
    else if (din_valid && din_ready) src_idx <= src_idx + 1;
  end
  assign din_valid = (src_idx < src_len) && !(stall_en && cyc == 2'b01);
  assign din_data = pat(src_idx);

  task automatic check(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic run_pgm(int len, logic [7:0] col, logic [23:0] row, bit spare,
                         bit fail, int blen, bit poll, int lo, int hi, bit stall);
    int w, exp_code, base, exp_n, e_cmd, e_addr, e_dat, off;
    bit rej, tmo;
    @(negedge clk);
    tst_clr = 1; cfg_poll = poll; cfg_we_lo = 4'(lo); cfg_we_hi = 4'(hi);
    busy_len = blen; fail_flag = fail; exp_lo = lo; exp_hi = hi;
    src_len = len; stall_en = stall;
    @(negedge clk);
    tst_clr = 0; req_valid = 1; req_len = 10'(len); req_col = col;
    req_row = row; req_spare = spare;
    @(negedge clk);
    req_valid = 0;
    w = 0;
    while (!resp_valid && w < 30000) begin @(negedge clk); w++; end
    rej = (len == 0) || (len > PAGE);
    tmo = !rej && (blen > TMO);
    exp_code = rej ? 3 : (tmo ? 2 : (fail ? 1 : 0));
    check(resp_valid && resp_code == 2'(exp_code),
          rej ? "R4" : (tmo ? "R10" : "R8"), "response code", int'(resp_code), exp_code);
    @(negedge clk);
    check(!resp_valid && nf_ce_n, "R11", "pulse end / ce high", int'({resp_valid, nf_ce_n}), 1);
    if (rej) begin
      check(log_n == 0 && !ce_seen && n_reads == 0, "R4", "bus quiet on refusal",
            log_n + int'(ce_seen), 0);
      return;
    end
    off = spare ? 1 : 0;
    base = off + 1 + 4 + len + 1;
    exp_n = base + (tmo ? (poll ? 2 : 1) : 1);
    check(log_n == exp_n, "R1", "write cycle count", log_n, exp_n);
    e_cmd = 0; e_addr = 0; e_dat = 0;
    for (int k = 0; k < exp_n && k < log_n; k++) begin
      if (k < off) begin
        if (log_k[k] != 2'd1 || log_v[k] != 8'h50) e_cmd++;
      end else if (k == off) begin
        if (log_k[k] != 2'd1 || log_v[k] != 8'h80) e_cmd++;
      end else if (k <= off + 4) begin
        logic [7:0] ev;
        int a = k - off - 1;
        ev = (a == 0) ? col : row[8*(a-1) +: 8];
        if (log_k[k] != 2'd2 || log_v[k] != ev) e_addr++;
      end else if (k < off + 5 + len) begin
        if (log_k[k] != 2'd0 || log_v[k] != pat(k - off - 5)) e_dat++;
      end else if (k == base - 1) begin
        if (log_k[k] != 2'd1 || log_v[k] != 8'h10) e_cmd++;
      end else if (k == exp_n - 1 && tmo) begin
        if (log_k[k] != 2'd1 || log_v[k] != 8'hFF) e_cmd++;
      end else begin
        if (log_k[k] != 2'd1 || log_v[k] != 8'h70) e_cmd++;
      end
    end
    check(e_cmd == 0, tmo ? "R10" : "R1", "command cycles", e_cmd, 0);
    check(e_addr == 0, "R2", "address bytes", e_addr, 0);
    check(e_dat == 0, "R3", "data bytes", e_dat, 0);
    check(src_idx == len, "R3", "bytes consumed", src_idx, len);
    check(bad_w == 0, "R5", "strobe widths", bad_w, 0);
    check(bad_cmd == 0, "R9", "writes while busy", bad_cmd, 0);
    if (!tmo && !poll) check(n_reads == 1, "R6", "status reads", n_reads, 1);
    if (!tmo && poll)  check(n_reads >= 2, "R7", "status reads", n_reads, 2);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lens [4] = '{1, 2, 5, 17};
    rst_n = 0; req_valid = 0; req_len = '0; req_col = '0; req_row = '0;
    req_spare = 0; cfg_poll = 0; cfg_we_lo = 4'd1; cfg_we_hi = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && nf_ce_n && nf_we_n && nf_re_n && !resp_valid, "R11",
          "reset state", int'({req_ready, nf_ce_n, nf_we_n, nf_re_n, resp_valid}), 30);
    for (int t = 0; t < 2; t++)
      for (int li = 0; li < 4; li++)
        for (int sp = 0; sp < 2; sp++)
          for (int pl = 0; pl < 2; pl++)
            for (int fl = 0; fl < 2; fl++)
              run_pgm(lens[li], 8'(8'h3C + li + sp), 24'h5A_C3_00 + 24'(li * 257 + t),
                      sp[0], fl[0], 20 + 13 * pl + 7 * fl, pl[0],
                      t == 0 ? 1 : 3, t == 0 ? 1 : 2, (li + fl) % 2 == 1);
    run_pgm(PAGE, 8'h00, 24'hABCDEF, 0, 0, 40, 1, 2, 3, 1);
    run_pgm(0, 8'h01, 24'h000001, 0, 0, 40, 0, 1, 1, 0);
    run_pgm(PAGE + 1, 8'h02, 24'h000002, 1, 0, 40, 1, 1, 1, 0);
    run_pgm(3, 8'h04, 24'h123456, 0, 0, 5000, 0, 1, 1, 0);
    run_pgm(4, 8'h05, 24'h654321, 1, 1, 5000, 1, 2, 2, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule